// File: doc/BRIEF.md
# Multiplexed External Bus Master

This block is a single-transfer master for a shared external bus whose address and data travel on the same lines. An internal requester hands it an address, byte enables, write data and a read/write flag. The block asks for the bus with a HOLD line, waits for the arbiter's grant on HLDA, and then drives one cycle of the form "latch strobe, then active-low read or write strobe". When the transfer ends it reports done, with read data on a read. It then releases HOLD and keeps the command lines driven to their inactive levels until the grant is withdrawn.

Three 4-bit counts set the timing. One stretches the address-latch phase, one stretches the strobe phase, and one lengthens the minimum time HOLD stays low before the next request may raise it. If the grant disappears in the middle of a transfer, the block stops driving the bus one clock later. It reports the transfer as done with an error and does not try it again. `req_valid` is a level. The requester keeps it high until it sees `done`, and drops it in that same cycle.

Top module: `xbus_master`

## Requirements
- R1: During and right after reset, HOLD is low, command and address/data enables are off, `done` is low, the latch strobe is low and both strobes are high.
- R2: In any cycle that follows a clock edge at which HLDA was sampled low, neither the command outputs nor the address/data lines are driven.
- R3: Take cycle 0 as the cycle in which HLDA is first sampled high while HOLD is high. From cycle 1 until the strobe phase ends, HOLD is high, the command outputs are driven and the byte enables show the inverted request enables (`bus_be_n = ~req_be`). The address/data lines are first driven in cycle 2.
- R4: The latch strobe is high in cycles 3 through 3+A, where A is `alat_cnt`.
- R5: In cycles 2 through 4+A the address/data lines carry the request address with bit 31 forced to 1. This keeps the address valid for one cycle after the latch strobe falls.
- R6: On a write, the write data is driven from cycle 5+A onward, one cycle before the write strobe goes low. On a read, the address/data lines are not driven from cycle 5+A onward.
- R7: The selected strobe (`bus_rd_n` for a read, `bus_wr_n` for a write) is low in cycles 6+A through 6+A+S, where S is `strb_cnt`. The other strobe stays high.
- R8: `done` is high only in cycle 7+A+S, with `done_err` low. On a read, `rd_data` then holds the value that was on `bus_ad_in` at the edge where the read strobe rose.
- R9: On a write, the write data and byte enables are still driven in cycle 7+A+S.
- R10: In cycle 8+A+S, HOLD is low and the bus is parked: commands are driven, the latch strobe is low, both strobes are high, all `bus_be_n` bits are 1 and the address/data lines are off. One cycle after HLDA is sampled low, the command outputs are off.
- R11: If HLDA stays high and a new request arrives, the command outputs stay driven through the HOLD-low gap and the cycle in which HOLD rises, and the new transfer follows the R3 to R8 timing.
- R12: Once HOLD falls, it stays low for at least 1+G cycles, where G is `gap_cnt`. With a request already pending, it rises after exactly 1+G cycles.
- R13: If HLDA is sampled low while HOLD is high after the grant, the next cycle has HOLD low, every bus output off, `done` and `done_err` both high, and `rd_data` equal to 0. The transfer is not reissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending (level, held until done) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Transfer address |
| req_be | input | 4 | Byte enables, active high |
| req_wdata | input | 32 | Write data |
| alat_cnt | input | 4 | Extra cycles of latch-strobe high time |
| strb_cnt | input | 4 | Extra cycles of strobe low time |
| gap_cnt | input | 4 | Extra cycles of HOLD low time between requests |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | With done: transfer aborted by grant loss |
| rd_data | output | 32 | Captured read data |
| bus_hold | output | 1 | Bus request to arbiter |
| bus_hlda | input | 1 | Grant from arbiter |
| bus_cmd_oe | output | 1 | Drive enable for latch strobe, strobes and byte enables |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_be_n | output | 4 | Byte enables, active low |
| bus_ad_oe | output | 1 | Drive enable for address/data lines |
| bus_ad_out | output | 32 | Address/data value driven |
| bus_ad_in | input | 32 | Address/data value sampled |

## Verification
Every timed result is counted from the cycle in which the grant is first sampled high. The commands follow 1 cycle later, the address 2, the latch strobe 3, and the strobe at 6+A. `done` arrives at 7+A+S and parking at 8+A+S. The bench therefore counts falling edges from that cycle and compares each output against a window worked out from the vector's A and S. The HOLD-low gap is counted the same way, from the parking cycle to the falling edge at which HOLD is seen high again. Abort effects are checked at the first falling edge after the edge that samples the lost grant.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_REQ, S_CMD, S_ADR, S_ALE, S_AHLD, S_PRE, S_STB, S_TAIL
  } xbm_state_e;

  // states in which the master owns and drives the command lines
  function automatic logic owns_bus(xbm_state_e s);
    return (s == S_CMD) || (s == S_ADR) || (s == S_ALE) || (s == S_AHLD) ||
           (s == S_PRE) || (s == S_STB) || (s == S_TAIL);
  endfunction

  // states in which losing the grant drops the transfer
  function automatic logic abortable(xbm_state_e s);
    return (s == S_CMD) || (s == S_ADR) || (s == S_ALE) || (s == S_AHLD) ||
           (s == S_PRE) || (s == S_STB);
  endfunction

  function automatic logic addr_phase(xbm_state_e s);
    return (s == S_ADR) || (s == S_ALE) || (s == S_AHLD);
  endfunction

  function automatic logic data_phase(xbm_state_e s);
    return (s == S_PRE) || (s == S_STB) || (s == S_TAIL);
  endfunction

  function automatic logic hold_high(xbm_state_e s);
    return (s == S_REQ) || owns_bus(s);
  endfunction

endpackage

// File: rtl/xbm_seq.sv
module xbm_seq
  import xbm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             hlda,
  input  logic [CNT_W-1:0] alat_cnt,
  input  logic [CNT_W-1:0] strb_cnt,
  input  logic [CNT_W-1:0] gap_cnt,
  output xbm_state_e       state,
  output logic             parked,
  output logic             accept,
  output logic             abort_ev,
  output logic             strobe_end
);

  xbm_state_e       nxt;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign abort_ev   = abortable(state) && !hlda;
  assign accept     = req_valid && ((state == S_IDLE) || ((state == S_GAP) && cnt_zero));
  assign strobe_end = (state == S_STB) && cnt_zero && hlda;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (accept) nxt = S_REQ;
      S_GAP:  if (cnt_zero) nxt = accept ? S_REQ : S_IDLE;
      S_REQ:  if (hlda) nxt = S_CMD;
      S_CMD:  nxt = S_ADR;
      S_ADR:  nxt = S_ALE;
      S_ALE:  if (cnt_zero) nxt = S_AHLD;
      S_AHLD: nxt = S_PRE;
      S_PRE:  nxt = S_STB;
      S_STB:  if (cnt_zero) nxt = S_TAIL;
      S_TAIL: nxt = S_GAP;
      default: nxt = S_IDLE;
    endcase
    if (abort_ev) nxt = S_GAP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        case (nxt)
          S_ALE:   cnt <= alat_cnt;
          S_STB:   cnt <= strb_cnt;
          S_GAP:   cnt <= gap_cnt;
          default: cnt <= '0;
        endcase
      end else if (!cnt_zero) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // park: keep commands driven while the grant lingers after a transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                parked <= 1'b0;
    else if (!hlda)            parked <= 1'b0;
    else if (state == S_TAIL)  parked <= 1'b1;
    else if (nxt == S_CMD)     parked <= 1'b0;
  end

endmodule

// File: rtl/xbm_pins.sv
module xbm_pins
  import xbm_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  xbm_state_e      state,
  input  logic            parked,
  input  logic            wr,
  input  logic [BE_W-1:0] be,
  input  logic [AD_W-1:0] addr,
  input  logic [AD_W-1:0] wdata,
  output logic            hold,
  output logic            cmd_oe,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic [BE_W-1:0] be_n,
  output logic            ad_oe,
  output logic [AD_W-1:0] ad_out
);

  logic drv;

  always_comb begin
    drv    = owns_bus(state);
    hold   = hold_high(state);
    cmd_oe = drv || parked;
    ale    = (state == S_ALE);
    rd_n   = !((state == S_STB) && !wr);
    wr_n   = !((state == S_STB) && wr);
    be_n   = drv ? ~be : '1;
    ad_oe  = addr_phase(state) || (wr && data_phase(state));
    if (addr_phase(state))           ad_out = addr;
    else if (wr && data_phase(state)) ad_out = wdata;
    else                             ad_out = '0;
  end

endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbm_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AD_W-1:0]      req_addr,
  input  logic [AD_W/8-1:0]    req_be,
  input  logic [AD_W-1:0]      req_wdata,
  input  logic [CNT_W-1:0]     alat_cnt,
  input  logic [CNT_W-1:0]     strb_cnt,
  input  logic [CNT_W-1:0]     gap_cnt,
  output logic                 done,
  output logic                 done_err,
  output logic [AD_W-1:0]      rd_data,
  output logic                 bus_hold,
  input  logic                 bus_hlda,
  output logic                 bus_cmd_oe,
  output logic                 bus_ale,
  output logic                 bus_rd_n,
  output logic                 bus_wr_n,
  output logic [AD_W/8-1:0]    bus_be_n,
  output logic                 bus_ad_oe,
  output logic [AD_W-1:0]      bus_ad_out,
  input  logic [AD_W-1:0]      bus_ad_in
);

  localparam int BE_W = AD_W / 8;

  // every bus address carries its top bit set
  function automatic logic [AD_W-1:0] force_top(logic [AD_W-1:0] a);
    return a | {1'b1, {(AD_W-1){1'b0}}};
  endfunction

  xbm_state_e      state;
  logic            parked, accept, abort_ev, strobe_end;
  logic            wr_q;
  logic [BE_W-1:0] be_q;
  logic [AD_W-1:0] addr_q, wd_q, rd_q;
  logic            done_q, err_q;

  xbm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hlda(bus_hlda),
    .alat_cnt(alat_cnt), .strb_cnt(strb_cnt), .gap_cnt(gap_cnt),
    .state(state), .parked(parked), .accept(accept),
    .abort_ev(abort_ev), .strobe_end(strobe_end)
  );

  xbm_pins #(.AD_W(AD_W), .BE_W(BE_W)) u_pins (
    .state(state), .parked(parked), .wr(wr_q), .be(be_q),
    .addr(addr_q), .wdata(wd_q),
    .hold(bus_hold), .cmd_oe(bus_cmd_oe), .ale(bus_ale),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .be_n(bus_be_n),
    .ad_oe(bus_ad_oe), .ad_out(bus_ad_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      be_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      be_q   <= req_be;
      addr_q <= force_top(req_addr);
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= strobe_end || abort_ev;
      err_q  <= abort_ev;
      if (strobe_end && !wr_q) rd_q <= bus_ad_in;
      else if (abort_ev)       rd_q <= '0;
    end
  end

  assign done     = done_q;
  assign done_err = err_q;
  assign rd_data  = rd_q;

endmodule

// File: rtl/xbm_chk.sv
module xbm_chk #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold,
  input logic            hlda,
  input logic            cmd_oe,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic [BE_W-1:0] be_n,
  input logic            ad_oe,
  input logic [AD_W-1:0] ad_out,
  input logic            done,
  input logic            done_err,
  input logic            abort_ev
);

  // R2
  released_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hlda) |-> (!cmd_oe && !ad_oe));

  // R4
  ale_with_address_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && cmd_oe && hold));

  // R5
  addr_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && $past(hlda)) |-> (ad_oe && $stable(ad_out)));

  // R6
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R6
  write_data_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (ad_oe && $past(ad_oe) && $stable(ad_out)));

  // R8
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (hold && rd_n && wr_n && $past(!rd_n || !wr_n)));

  // R10
  park_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oe && !hold) |-> (!ale && rd_n && wr_n && !ad_oe && (be_n == '1)));

  // R13
  abort_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (done && done_err && !hold && !cmd_oe && !ad_oe));

endmodule

bind xbus_master xbm_chk #(.AD_W(AD_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(bus_hold), .hlda(bus_hlda),
  .cmd_oe(bus_cmd_oe), .ale(bus_ale), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
  .be_n(bus_be_n), .ad_oe(bus_ad_oe), .ad_out(bus_ad_out),
  .done(done), .done_err(done_err), .abort_ev(abort_ev)
);

// File: tb/xbus_master_test.sv
module xbus_master_test;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [3:0]  a;
    logic [3:0]  s;
    logic [3:0]  g;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 32'h0000_1000, 4'hF, 32'hA5A5_0001, 4'd0, 4'd0, 4'd0},
    '{1'b0, 32'h0123_4560, 4'h3, 32'h5A5A_1234, 4'd2, 4'd1, 4'd3},
    '{1'b1, 32'h7FFF_FFFC, 4'h8, 32'hDEAD_BEEF, 4'd1, 4'd3, 4'd1},
    '{1'b0, 32'h8000_0040, 4'hF, 32'h0F0F_F0F0, 4'd0, 4'd0, 4'd0},
    '{1'b1, 32'h0000_0004, 4'h1, 32'h1234_5678, 4'd4, 4'd2, 4'd2},
    '{1'b0, 32'h00AB_CDE8, 4'hC, 32'hCAFE_F00D, 4'd3, 4'd5, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, bus_ad_in = '0;
  logic [3:0]  req_be = '0, alat_cnt = '0, strb_cnt = '0, gap_cnt = '0;
  logic        bus_hlda = 1'b0;
  logic        done, done_err, bus_hold, bus_cmd_oe, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
  logic [3:0]  bus_be_n;
  logic [31:0] rd_data, bus_ad_out;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  xbus_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .alat_cnt(alat_cnt), .strb_cnt(strb_cnt), .gap_cnt(gap_cnt),
    .done(done), .done_err(done_err), .rd_data(rd_data),
    .bus_hold(bus_hold), .bus_hlda(bus_hlda), .bus_cmd_oe(bus_cmd_oe),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_be_n(bus_be_n), .bus_ad_oe(bus_ad_oe), .bus_ad_out(bus_ad_out),
    .bus_ad_in(bus_ad_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // mode 0: no gap checks, 1: grant was released, 2: grant kept high (parked)
  task automatic xfer(input vec_t v, input int prev_g, input int mode, input bit release_after);
    int low, a, s, endc;
    logic exp_oe;
    a = int'(v.a); s = int'(v.s); endc = 7 + a + s;
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_be = v.be;
    req_wdata = v.data; alat_cnt = v.a; strb_cnt = v.s; gap_cnt = v.g;
    bus_ad_in = v.data;
    low = 0;
    while (!bus_hold) begin
      if (mode == 2) chk(bus_cmd_oe == 1'b1, "R11 cmd held in gap", bus_cmd_oe, 1);
      low++;
      step();
      if (mode == 1 && low == 1) chk(bus_cmd_oe == 1'b0, "R10 cmd off after grant drop", bus_cmd_oe, 0);
    end
    if (mode != 0) chk(low == prev_g + 1, "R12 hold low cycles", low, prev_g + 1);
    if (mode == 2) chk(bus_cmd_oe == 1'b1, "R11 cmd held at hold rise", bus_cmd_oe, 1);
    chk(bus_ad_oe == 1'b0 && bus_ale == 1'b0, "R3 idle at hold rise", {bus_ad_oe, bus_ale}, 0);
    bus_hlda = 1'b1;
    for (int i = 1; i <= endc; i++) begin
      step();
      chk(bus_hold && bus_cmd_oe, "R3 hold/cmd", {bus_hold, bus_cmd_oe}, 2'b11);
      chk(bus_be_n == ~v.be, "R3 byte enables", bus_be_n, ~v.be);
      chk(bus_ale == (i >= 3 && i <= 3 + a), "R4 latch strobe", bus_ale, (i >= 3 && i <= 3 + a));
      exp_oe = (i >= 2 && i <= 4 + a) || (v.wr && i >= 5 + a);
      chk(bus_ad_oe == exp_oe, (i < 2) ? "R3 ad enable" : (i <= 4 + a) ? "R5 ad enable" :
          (i == endc) ? "R9 ad enable" : "R6 ad enable", bus_ad_oe, exp_oe);
      if (i >= 2 && i <= 4 + a)
        chk(bus_ad_out == (v.addr | 32'h8000_0000), "R5 address", bus_ad_out, v.addr | 32'h8000_0000);
      if (v.wr && i >= 5 + a)
        chk(bus_ad_out == v.data, (i == endc) ? "R9 write data" : "R6 write data", bus_ad_out, v.data);
      chk(bus_rd_n == !(!v.wr && i >= 6 + a && i <= 6 + a + s), "R7 read strobe", bus_rd_n,
          !(!v.wr && i >= 6 + a && i <= 6 + a + s));
      chk(bus_wr_n == !(v.wr && i >= 6 + a && i <= 6 + a + s), "R7 write strobe", bus_wr_n,
          !(v.wr && i >= 6 + a && i <= 6 + a + s));
      chk(done == (i == endc), "R8 done timing", done, (i == endc));
      if (i == endc) begin
        chk(done_err == 1'b0, "R8 no error", done_err, 0);
        if (!v.wr) chk(rd_data == v.data, "R8 read data", rd_data, v.data);
        req_valid = 1'b0;
      end
    end
    step();
    chk(!bus_hold && bus_cmd_oe, "R10 parked hold/cmd", {bus_hold, bus_cmd_oe}, 2'b01);
    chk(!bus_ale && bus_rd_n && bus_wr_n && bus_be_n == 4'hF && !bus_ad_oe, "R10 parked levels",
        {bus_ale, bus_rd_n, bus_wr_n, bus_be_n, bus_ad_oe}, 8'b0_1_1_1111_0);
    chk(done == 1'b0, "R8 done single pulse", done, 0);
    if (release_after) bus_hlda = 1'b0;
  endtask

  localparam vec_t PARK1 = '{1'b1, 32'h0000_0100, 4'h6, 32'h0BAD_CAFE, 4'd0, 4'd0, 4'd2};
  localparam vec_t PARK2 = '{1'b0, 32'h0000_0200, 4'h9, 32'h7777_1111, 4'd1, 4'd0, 4'd0};

  initial begin
    int stray;
    step();
    // R1 reset state
    chk(!bus_hold && !bus_cmd_oe && !bus_ad_oe && !done, "R1 reset outputs",
        {bus_hold, bus_cmd_oe, bus_ad_oe, done}, 0);
    chk(!bus_ale && bus_rd_n && bus_wr_n, "R1 reset strobes", {bus_ale, bus_rd_n, bus_wr_n}, 3'b011);
    step(); step();
    rst_n = 1'b1;
    step();
    chk(!bus_hold && !bus_cmd_oe && !done, "R1 after reset", {bus_hold, bus_cmd_oe, done}, 0);

    for (int k = 0; k < 6; k++)
      xfer(VECS[k], (k > 0) ? int'(VECS[k-1].g) : 0, (k > 0) ? 1 : 0, 1'b1);

    // grant kept high after PARK1: PARK2 reuses the parked command bus (R11)
    xfer(PARK1, int'(VECS[5].g), 1, 1'b0);
    xfer(PARK2, int'(PARK1.g), 2, 1'b0);

    // R10 release while parked
    bus_hlda = 1'b0;
    step();
    chk(bus_cmd_oe == 1'b0, "R10 cmd off after park release", bus_cmd_oe, 0);

    // R13 abort during the latch phase of a read
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0300; req_be = 4'hF;
    alat_cnt = 4'd2; strb_cnt = 4'd0; gap_cnt = 4'd0; bus_ad_in = 32'h1357_9BDF;
    while (!bus_hold) step();
    bus_hlda = 1'b1;
    for (int i = 1; i <= 4; i++) step();
    chk(bus_ale == 1'b1, "R4 latch strobe before abort", bus_ale, 1);
    bus_hlda = 1'b0;
    step();
    chk(!bus_cmd_oe && !bus_ad_oe, "R2 lines off after grant loss", {bus_cmd_oe, bus_ad_oe}, 0);
    chk(!bus_hold, "R13 hold dropped", bus_hold, 0);
    chk(done && done_err, "R13 done with error", {done, done_err}, 2'b11);
    chk(rd_data == 32'h0, "R13 no read data", rd_data, 0);
    req_valid = 1'b0;
    stray = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (bus_hold || done || bus_cmd_oe) stray++;
    end
    chk(stray == 0, "R13 no reissue", stray, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule